// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block holds the programming registers of a small bank of DMA channels. Each channel has a 16-bit base address and a 16-bit base count, both loaded one byte at a time through an 8-bit port. It also keeps a current address and a current transferred count, which the transfer sequencer uses. A single byte pointer is shared by every channel and decides which half of a register the next access touches. Software clears the pointer with a strobe and then writes or reads low byte first, high byte second.

A port index picks the channel and the register. Its upper bits give the channel number and bit 0 gives the register. Completing the high byte of a write restarts the channel: the current address is reloaded from the base and the transferred count is cleared. Reads do not return the stored bases. They return live progress: the address reached so far, or the number of units still remaining. For wide-unit controllers, every value is scaled by a size shift.

Top module: `dmareg_bank`

## Requirements
- R1: After reset the byte pointer is 0 and every base and current register of every channel is 0.
- R2: The byte pointer inverts at the end of any cycle with a read, a write, or both. When a read and a write fall in the same cycle, it inverts exactly once. Without an access and without a clear it holds.
- R3: The clear strobe sets the byte pointer to 0 in the next cycle. This overrides any toggle from an access in the same cycle.
- R4: In the port index, bits [3:1] select the channel and bit 0 selects the register (0 = address, 1 = count). A write while the pointer is 0 replaces bits [7:0] of the selected base register. The other byte and all other registers stay unchanged.
- R5: A write while the pointer is 1 replaces bits [15:8] of the selected base register. In the same step, that channel's current address becomes its new base address shifted left by SIZE_SHIFT, and its current count becomes 0. This reload overrides a sequencer count update to the same channel in the same cycle.
- R6: A sequencer update loads the given value into the current count of the named channel.
- R7: An address read returns a byte of (current address + current count), or of (current address - current count) when the channel's down-count input is 1. The arithmetic is modulo 2^(17+SIZE_SHIFT).
- R8: A count read returns a byte of ((base count << SIZE_SHIFT) - current count), with the same wrap.
- R9: The read byte is bits [SIZE_SHIFT+8p+7 : SIZE_SHIFT+8p] of the value, where p is the pointer before the access. It is presented combinationally in the cycle of the read.
- R10: An index whose channel number is NUM_CH or higher changes no register on a write and reads as 0x00. It still toggles the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_idx | input | IDX_W | Port index of the write |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Byte read strobe |
| rd_idx | input | IDX_W | Port index of the read |
| rd_data | output | 8 | Read byte, valid in the read cycle |
| ptr_clr | input | 1 | Clear-pointer strobe (also driven on master reset command) |
| dir_down | input | NUM_CH | Per-channel address direction, 1 = decrement |
| seq_upd | input | 1 | Sequencer count update strobe |
| seq_ch | input | CH_W | Channel of the count update |
| seq_cnt | input | CNT_W | New transferred count |
| byte_ptr | output | 1 | Shared byte pointer |
| base_addr_o | output | NUM_CH*16 | Base addresses, channel 0 in the low slice |
| base_cnt_o | output | NUM_CH*16 | Base counts |
| cur_addr_o | output | NUM_CH*VAL_W | Current addresses (scaled) |
| cur_cnt_o | output | NUM_CH*CNT_W | Current transferred counts |

## Verification
The assertions assume the access strobes and the clear strobe are sampled only after the internal reset has been released. They also assume a sequencer update never names a channel number at or above NUM_CH, which the channel-select width rules out for power-of-two counts. The stimulus waits several cycles after reset and draws the sequencer channel from the valid range. It also mixes in out-of-range port indexes for both reads and writes, and same-cycle collisions of read, write, clear and count update.

// File: rtl/dmareg_pkg.sv
`timescale 1ns/1ps
package dmareg_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dmareg_ptr.sv
`timescale 1ns/1ps
module dmareg_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rd_en,
  input  logic wr_en,
  output logic ptr
);
  logic ptr_q;
  logic ptr_d;
  logic ptr_ce;

  // one toggle per cycle no matter how many accesses; clear wins
  always_comb begin
    ptr_ce = clr | rd_en | wr_en;
    ptr_d  = clr ? 1'b0 : ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= 1'b0;
    end else if (ptr_ce) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/dmareg_chan.sv
`timescale 1ns/1ps
module dmareg_chan
  import dmareg_pkg::*;
#(
  parameter int SIZE_SHIFT = 1,
  parameter int VAL_W      = REG_W + SIZE_SHIFT,
  parameter int CNT_W      = VAL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  reg_sel_e         wr_reg,
  input  logic             wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic             cnt_upd,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [REG_W-1:0] base_a,
  output logic [REG_W-1:0] base_c,
  output logic [VAL_W-1:0] cur_a,
  output logic [CNT_W-1:0] cur_c
);
  logic [REG_W-1:0] base_a_q, base_a_d;
  logic [REG_W-1:0] base_c_q, base_c_d;
  logic [VAL_W-1:0] cur_a_q, cur_a_d;
  logic [CNT_W-1:0] cur_c_q, cur_c_d;
  logic             ld_ce;

  always_comb begin
    base_a_d = base_a_q;
    base_c_d = base_c_q;
    cur_a_d  = cur_a_q;
    cur_c_d  = cur_c_q;
    ld_ce    = wr_sel | cnt_upd;
    if (cnt_upd) begin
      cur_c_d = cnt_val;
    end
    if (wr_sel) begin
      if (wr_reg == SEL_ADDR) begin
        if (wr_hi) base_a_d[REG_W-1:BYTE_W] = wr_data;
        else       base_a_d[BYTE_W-1:0]     = wr_data;
      end else begin
        if (wr_hi) base_c_d[REG_W-1:BYTE_W] = wr_data;
        else       base_c_d[BYTE_W-1:0]     = wr_data;
      end
      // completing the high byte restarts the channel
      if (wr_hi) begin
        cur_a_d = VAL_W'(base_a_d) << SIZE_SHIFT;
        cur_c_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_a_q <= '0;
      base_c_q <= '0;
      cur_a_q  <= '0;
      cur_c_q  <= '0;
    end else if (ld_ce) begin
      base_a_q <= base_a_d;
      base_c_q <= base_c_d;
      cur_a_q  <= cur_a_d;
      cur_c_q  <= cur_c_d;
    end
  end

  assign base_a = base_a_q;
  assign base_c = base_c_q;
  assign cur_a  = cur_a_q;
  assign cur_c  = cur_c_q;
endmodule

// File: rtl/dmareg_rdmux.sv
`timescale 1ns/1ps
module dmareg_rdmux
  import dmareg_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int IDX_W      = 4,
  parameter int SIZE_SHIFT = 1,
  parameter int CH_W       = $clog2(NUM_CH),
  parameter int VAL_W      = REG_W + SIZE_SHIFT,
  parameter int CNT_W      = VAL_W + 1
) (
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              byte_ptr,
  input  logic [NUM_CH-1:0] dir_down,
  input  logic [REG_W-1:0]  base_c [NUM_CH],
  input  logic [VAL_W-1:0]  cur_a  [NUM_CH],
  input  logic [CNT_W-1:0]  cur_c  [NUM_CH],
  output logic [BYTE_W-1:0] rd_data
);
  localparam logic [IDX_W-1:0] NCH_LIM = IDX_W'(NUM_CH);

  logic [IDX_W-2:0] rd_ch;
  logic             rd_ok;
  logic [CH_W-1:0]  sel;
  logic [CNT_W-1:0] val;

  assign rd_ch = rd_idx[IDX_W-1:1];
  assign rd_ok = ({1'b0, rd_ch} < NCH_LIM);
  assign sel   = rd_ch[CH_W-1:0];

  always_comb begin
    val     = '0;
    rd_data = '0;
    if (rd_ok) begin
      if (reg_sel_e'(rd_idx[0]) == SEL_CNT) begin
        val = (CNT_W'(base_c[sel]) << SIZE_SHIFT) - cur_c[sel];
      end else if (dir_down[sel]) begin
        val = CNT_W'(cur_a[sel]) - cur_c[sel];
      end else begin
        val = CNT_W'(cur_a[sel]) + cur_c[sel];
      end
      rd_data = BYTE_W'(val >> (SIZE_SHIFT + BYTE_W * int'(byte_ptr)));
    end
  end
endmodule

// File: rtl/dmareg_bank.sv
`timescale 1ns/1ps
module dmareg_bank
  import dmareg_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int IDX_W      = 4,
  parameter int SIZE_SHIFT = 1,
  parameter int CH_W       = $clog2(NUM_CH),
  parameter int VAL_W      = REG_W + SIZE_SHIFT,
  parameter int CNT_W      = VAL_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [BYTE_W-1:0]       wr_data,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [BYTE_W-1:0]       rd_data,
  input  logic                    ptr_clr,
  input  logic [NUM_CH-1:0]       dir_down,
  input  logic                    seq_upd,
  input  logic [CH_W-1:0]         seq_ch,
  input  logic [CNT_W-1:0]        seq_cnt,
  output logic                    byte_ptr,
  output logic [NUM_CH*REG_W-1:0] base_addr_o,
  output logic [NUM_CH*REG_W-1:0] base_cnt_o,
  output logic [NUM_CH*VAL_W-1:0] cur_addr_o,
  output logic [NUM_CH*CNT_W-1:0] cur_cnt_o
);
  localparam logic [IDX_W-1:0] NCH_LIM = IDX_W'(NUM_CH);

  // reset: asserted at once, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [IDX_W-2:0] wr_ch;
  logic             wr_ok;
  logic             ptr;

  assign wr_ch = wr_idx[IDX_W-1:1];
  assign wr_ok = ({1'b0, wr_ch} < NCH_LIM);

  dmareg_ptr u_ptr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (ptr_clr),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .ptr   (ptr)
  );

  logic [REG_W-1:0] base_a [NUM_CH];
  logic [REG_W-1:0] base_c [NUM_CH];
  logic [VAL_W-1:0] cur_a  [NUM_CH];
  logic [CNT_W-1:0] cur_c  [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_sel;
    logic upd;

    assign wr_sel = wr_en & wr_ok & (wr_ch == (IDX_W-1)'(c));
    assign upd    = seq_upd & (seq_ch == CH_W'(c));

    dmareg_chan #(
      .SIZE_SHIFT (SIZE_SHIFT),
      .VAL_W      (VAL_W),
      .CNT_W      (CNT_W)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_sel  (wr_sel),
      .wr_reg  (reg_sel_e'(wr_idx[0])),
      .wr_hi   (ptr),
      .wr_data (wr_data),
      .cnt_upd (upd),
      .cnt_val (seq_cnt),
      .base_a  (base_a[c]),
      .base_c  (base_c[c]),
      .cur_a   (cur_a[c]),
      .cur_c   (cur_c[c])
    );

    assign base_addr_o[c*REG_W +: REG_W] = base_a[c];
    assign base_cnt_o [c*REG_W +: REG_W] = base_c[c];
    assign cur_addr_o [c*VAL_W +: VAL_W] = cur_a[c];
    assign cur_cnt_o  [c*CNT_W +: CNT_W] = cur_c[c];
  end

  dmareg_rdmux #(
    .NUM_CH     (NUM_CH),
    .IDX_W      (IDX_W),
    .SIZE_SHIFT (SIZE_SHIFT),
    .CH_W       (CH_W),
    .VAL_W      (VAL_W),
    .CNT_W      (CNT_W)
  ) u_rdmux (
    .rd_idx   (rd_idx),
    .byte_ptr (ptr),
    .dir_down (dir_down),
    .base_c   (base_c),
    .cur_a    (cur_a),
    .cur_c    (cur_c),
    .rd_data  (rd_data)
  );

  assign byte_ptr = ptr;
endmodule

// File: rtl/dmareg_bank_chk.sv
`timescale 1ns/1ps
module dmareg_bank_chk
  import dmareg_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int IDX_W      = 4,
  parameter int SIZE_SHIFT = 1,
  parameter int CH_W       = $clog2(NUM_CH),
  parameter int VAL_W      = REG_W + SIZE_SHIFT,
  parameter int CNT_W      = VAL_W + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [IDX_W-1:0]        wr_idx,
  input logic [BYTE_W-1:0]       wr_data,
  input logic                    rd_en,
  input logic [IDX_W-1:0]        rd_idx,
  input logic [BYTE_W-1:0]       rd_data,
  input logic                    ptr_clr,
  input logic                    seq_upd,
  input logic [CH_W-1:0]         seq_ch,
  input logic [CNT_W-1:0]        seq_cnt,
  input logic                    byte_ptr,
  input logic [NUM_CH*REG_W-1:0] base_addr_o,
  input logic [NUM_CH*VAL_W-1:0] cur_addr_o,
  input logic [NUM_CH*CNT_W-1:0] cur_cnt_o
);
  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && !ptr_clr |=> byte_ptr != $past(byte_ptr));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en && !wr_en && !ptr_clr |=> $stable(byte_ptr));

  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !byte_ptr);

  // R10
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (int'(rd_idx[IDX_W-1:1]) >= NUM_CH) |-> rd_data == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R4
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !byte_ptr && (int'(wr_idx) == 2*c) |=>
        base_addr_o[c*REG_W +: BYTE_W] == $past(wr_data) &&
        base_addr_o[c*REG_W+BYTE_W +: BYTE_W] == $past(base_addr_o[c*REG_W+BYTE_W +: BYTE_W]));

    // R5
    hi_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && byte_ptr && (int'(wr_idx[IDX_W-1:1]) == c) |=>
        cur_cnt_o[c*CNT_W +: CNT_W] == '0 &&
        cur_addr_o[c*VAL_W +: VAL_W] == (VAL_W'(base_addr_o[c*REG_W +: REG_W]) << SIZE_SHIFT));

    // R6
    seq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_upd && (int'(seq_ch) == c) &&
      !(wr_en && byte_ptr && (int'(wr_idx[IDX_W-1:1]) == c)) |=>
        cur_cnt_o[c*CNT_W +: CNT_W] == $past(seq_cnt));
  end
endmodule

bind dmareg_bank dmareg_bank_chk #(
  .NUM_CH     (NUM_CH),
  .IDX_W      (IDX_W),
  .SIZE_SHIFT (SIZE_SHIFT),
  .CH_W       (CH_W),
  .VAL_W      (VAL_W),
  .CNT_W      (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .rd_en       (rd_en),
  .rd_idx      (rd_idx),
  .rd_data     (rd_data),
  .ptr_clr     (ptr_clr),
  .seq_upd     (seq_upd),
  .seq_ch      (seq_ch),
  .seq_cnt     (seq_cnt),
  .byte_ptr    (byte_ptr),
  .base_addr_o (base_addr_o),
  .cur_addr_o  (cur_addr_o),
  .cur_cnt_o   (cur_cnt_o)
);

// File: tb/dmareg_bank_tb.sv
`timescale 1ns/1ps
module dmareg_bank_tb;
  localparam int NCH = 4;
  localparam int S   = 1;
  localparam int VW  = 16 + S;
  localparam int CW  = VW + 1;

  logic clk;
  logic rst_n;
  logic wr_en, rd_en, ptr_clr, seq_upd;
  logic [3:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;
  logic [NCH-1:0] dir_down, dir_next;
  logic [1:0] seq_ch;
  logic [CW-1:0] seq_cnt;
  logic byte_ptr;
  logic [NCH*16-1:0] base_addr_o, base_cnt_o;
  logic [NCH*VW-1:0] cur_addr_o;
  logic [NCH*CW-1:0] cur_cnt_o;

  dmareg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .ptr_clr(ptr_clr),
    .dir_down(dir_down), .seq_upd(seq_upd), .seq_ch(seq_ch), .seq_cnt(seq_cnt),
    .byte_ptr(byte_ptr), .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o),
    .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model
  logic [15:0]   mba [NCH];
  logic [15:0]   mbc [NCH];
  logic [VW-1:0] mca [NCH];
  logic [CW-1:0] mcc [NCH];
  logic          mptr;

  int n_chk;
  int n_fail;
  bit done;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] idx, input logic p);
    logic [CW-1:0] v;
    int ch;
    ch = int'(idx[3:1]);
    if (ch >= NCH) return 8'h00;                         // R10
    if (idx[0]) v = (CW'(mbc[ch]) << S) - mcc[ch];       // R8
    else if (dir_down[ch]) v = CW'(mca[ch]) - mcc[ch];   // R7
    else v = CW'(mca[ch]) + mcc[ch];
    return 8'(v >> (S + 8 * int'(p)));                   // R9
  endfunction

  task automatic model_step();
    int ch;
    if (seq_upd) mcc[seq_ch] = seq_cnt;
    ch = int'(wr_idx[3:1]);
    if (wr_en && ch < NCH) begin
      if (!wr_idx[0]) begin
        if (mptr) mba[ch][15:8] = wr_data; else mba[ch][7:0] = wr_data;
      end else begin
        if (mptr) mbc[ch][15:8] = wr_data; else mbc[ch][7:0] = wr_data;
      end
      if (mptr) begin
        mca[ch] = VW'(mba[ch]) << S;
        mcc[ch] = '0;
      end
    end
    if (ptr_clr) mptr = 1'b0;
    else if (wr_en || rd_en) mptr = ~mptr;
  endtask

  task automatic check_state(input string req);
    chk({req, " R2 R3 ptr"}, 32'(byte_ptr), 32'(mptr));
    for (int c = 0; c < NCH; c++) begin
      chk({req, " R4 R5 base_addr"}, 32'(base_addr_o[c*16 +: 16]), 32'(mba[c]));
      chk({req, " R4 R5 base_cnt"}, 32'(base_cnt_o[c*16 +: 16]), 32'(mbc[c]));
      chk({req, " R5 cur_addr"}, 32'(cur_addr_o[c*VW +: VW]), 32'(mca[c]));
      chk({req, " R5 R6 cur_cnt"}, 32'(cur_cnt_o[c*CW +: CW]), 32'(mcc[c]));
    end
  endtask

  task automatic cyc(input logic w, input logic [3:0] wi, input logic [7:0] wd,
                     input logic r, input logic [3:0] ri, input logic c,
                     input logic su, input logic [1:0] sc, input logic [CW-1:0] sv,
                     input string req);
    @(negedge clk);
    wr_en = w; wr_idx = wi; wr_data = wd;
    rd_en = r; rd_idx = ri; ptr_clr = c;
    seq_upd = su; seq_ch = sc; seq_cnt = sv;
    dir_down = dir_next;
    #4;
    if (r) chk({req, " R9 rd_data"}, 32'(rd_data), 32'(exp_rd(ri, mptr)));
    @(posedge clk);
    model_step();
    #1;
    check_state(req);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    wr_en = 0; rd_en = 0; ptr_clr = 0; seq_upd = 0;
    wr_idx = '0; rd_idx = '0; wr_data = '0; seq_ch = '0; seq_cnt = '0;
    dir_down = '0; dir_next = '0;
    for (int c = 0; c < NCH; c++) begin
      mba[c] = '0; mbc[c] = '0; mca[c] = '0; mcc[c] = '0;
    end
    mptr = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_state("R1");

    // directed: program channel 1
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
    cyc(1, 4'd2, 8'h34, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 4'd2, 8'h12, 0, 0, 0, 0, 0, 0, "R5");
    cyc(1, 4'd3, 8'h0F, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 4'd3, 8'h00, 0, 0, 0, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, CW'(5), "R6");
    cyc(0, 0, 0, 1, 4'd2, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 1, 4'd2, 0, 0, 0, 0, "R7");
    dir_next = 4'b0010;
    cyc(0, 0, 0, 1, 4'd2, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 1, 4'd2, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 1, 4'd3, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 1, 4'd3, 0, 0, 0, 0, "R8");
    // count above base: wraps
    cyc(0, 0, 0, 0, 0, 0, 1, 2'd1, CW'(40), "R6");
    cyc(0, 0, 0, 1, 4'd3, 0, 0, 0, 0, "R8");
    // read and write in one cycle: single toggle
    cyc(1, 4'd4, 8'hAA, 1, 4'd2, 0, 0, 0, 0, "R2");
    cyc(1, 4'd4, 8'h55, 1, 4'd3, 0, 0, 0, 0, "R2");
    // clear together with access
    cyc(1, 4'd6, 8'h77, 1, 4'd6, 1, 0, 0, 0, "R3");
    // out-of-range indexes
    cyc(1, 4'd9, 8'hEE, 0, 0, 0, 0, 0, 0, "R10");
    cyc(1, 4'd14, 8'hDD, 1, 4'd12, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 1, 4'd15, 0, 0, 0, 0, "R10");
    // high write and count update on the same channel
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
    cyc(1, 4'd0, 8'h01, 0, 0, 0, 0, 0, 0, "R4");
    cyc(1, 4'd0, 8'h80, 0, 0, 0, 1, 2'd0, CW'(99), "R5");
    cyc(0, 0, 0, 1, 4'd0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 1, 4'd0, 0, 0, 0, 0, "R7");

    // constrained random
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] wi, ri;
      wi = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 8);
      ri = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 8);
      if ($urandom % 16 == 0) dir_next = 4'($urandom);
      cyc(1'($urandom % 2), wi, 8'($urandom), 1'($urandom % 2), ri,
          1'($urandom % 12 == 0), 1'($urandom % 4 == 0), 2'($urandom),
          CW'($urandom), "R2 R7 R8");
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule